// File: doc/BRIEF.md
# Variable-Length Burst SPI Master

This block is a SPI master (mode 0: clock idles low, data sampled on the rising edge) that moves bursts of programmable bit length between two word FIFOs and a serial line. Software fills a 32-bit transmit FIFO through a small register port, programs a burst length and a chip-select number, and sets a start bit. The engine shifts the burst out most significant bit first. It samples the return line on every rising edge and packs each received word into a 32-bit receive FIFO.

A burst whose length is not a multiple of 32 puts its leftover bits in the first word. That word supplies only its low bits, and every later word supplies a full 32. Clearing the enable bit works as a soft reset. It aborts any burst, releases every chip select and empties both FIFOs. It leaves the control register alone. While the block is disabled it ignores writes to every register except control, and reads of the other registers return their reset values.

Back-pressure on both queues is handled by stalling, not by dropping data. A TX push into a full FIFO is discarded, and the full flag in status shows it. A burst that runs out of TX data, or finds the RX FIFO full at a word boundary, waits with the clock low and chip select held until the condition clears.

Top module: `spim_top`

## Requirements
- R1: The control register (address 0) resets to zero. Bit 0 is enable, bit 1 is a start strobe that always reads 0, bits [3:2] select the chip select, and bits [15:4] hold the burst length minus one. Writes to control are accepted at all times and read back as written, with the start bit and bits above 15 reading 0.
- R2: A length field F gives N = F+1 bits, rounded up to the next multiple of 8. Exactly that many rising edges of spi_sclk occur in the burst.
- R3: The first TX word of a burst supplies its low (N mod 32) bits, or all 32 bits when N mod 32 is 0. Each further word supplies 32 bits. One word is popped per word slot.
- R4: Within a word, bits go out from the highest used bit down to bit 0. spi_mosi is stable while spi_sclk is low, and spi_sclk is high for exactly one clock per bit.
- R5: Each word slot pushes one RX word. Its received bits sit in the low positions, with the first received bit most significant, and zeros fill the bits above.
- R6: Writing control with enable=1 and start=1 begins a burst only when the engine is idle and the TX FIFO is not empty. Any other start request, and any control write without start, leaves the engine idle.
- R7: If the TX FIFO is empty or the RX FIFO is full at a word boundary, the burst stalls with spi_sclk low and chip select held. It resumes once the condition clears.
- R8: During a burst only the selected active-low spi_cs_n line is low. At all other times all lines are high, and spi_sclk only pulses while a line is low.
- R9: Clearing enable aborts the burst. By the next cycle all chip selects are high, spi_sclk is low and both FIFOs are empty. The control register keeps the written value.
- R10: While disabled, TX data writes are ignored, RXDATA (address 2) reads 0 and STATUS (address 3) reads 0x5.
- R11: STATUS bit 0 is TX empty, bit 1 TX full, bit 2 RX empty, bit 3 RX full and bit 4 busy. The FIFOs hold 8 words each, a push to a full TX FIFO (address 1) is dropped, and an RX read when empty returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe (pops RX on address 2) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
The assertions watch the serial pins on every cycle for the following:
- at most one chip select is low;
- the clock pulses only inside a selected transaction;
- every high phase lasts one clock;
- disabling the block releases the selects and empties the TX queue on the next cycle.

The bench's scenarios show what the assertions cannot:
- the bit count, bit order and word split of each burst, swept over every length field from 0 to 79 with the output looped back to the input;
- the stall points for an empty TX queue and a full RX queue;
- the gating of register writes and reads while disabled.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W = 32;
  localparam int EN_BIT = 0;
  localparam int GO_BIT = 1;
  localparam int CS_LSB = 2;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_TXD  = 2'd1,
    A_RXD  = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT
  } eng_state_e;

  localparam logic [4:0] STAT_RESET = 5'b00101;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign rdata = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) wr_ptr <= nxt(wr_ptr);
      if (pop && !empty) rd_ptr <= nxt(rd_ptr);
      count <= count + (AW+1)'(push && !full) - (AW+1)'(pop && !empty);
    end
  end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int CS_W   = 2,
  parameter int LEN_W  = 12,
  parameter int CTRL_W = 2 + CS_W + LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              tx_empty,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic              rx_full,
  input  logic [WORD_W-1:0] rx_head,
  input  logic              busy,
  output logic [WORD_W-1:0] rdata,
  output logic              en,
  output logic [CS_W-1:0]   cs_sel,
  output logic [LEN_W-1:0]  len_m1,
  output logic              start,
  output logic              tx_push,
  output logic              rx_pop
);
  localparam int LEN_LSB = CS_LSB + CS_W;

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      cs_sel <= '0;
      len_m1 <= '0;
      start  <= 1'b0;
    end else begin
      start <= ctrl_wr && ctrl_wdata[EN_BIT] && ctrl_wdata[GO_BIT];
      if (ctrl_wr) begin
        en     <= ctrl_wdata[EN_BIT];
        cs_sel <= ctrl_wdata[CS_LSB +: CS_W];
        len_m1 <= ctrl_wdata[LEN_LSB +: LEN_W];
      end
    end
  end

  assign tx_push = wr_en && (addr == A_TXD) && en && !tx_full;
  assign rx_pop  = rd_en && (addr == A_RXD) && en && !rx_empty;

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      A_CTRL: begin
        rdata[EN_BIT]              = en;
        rdata[CS_LSB +: CS_W]      = cs_sel;
        rdata[LEN_LSB +: LEN_W]    = len_m1;
      end
      A_RXD:  rdata = en ? rx_head : '0;
      A_STAT: rdata[4:0] = en ? {busy, rx_full, rx_empty, tx_full, tx_empty}
                              : STAT_RESET;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [CS_W-1:0]   cs_sel,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              rx_full,
  input  logic              miso,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int TOT_W  = LEN_W + 1;
  localparam int WCNT_W = TOT_W - 5;

  eng_state_e         state;
  logic [WCNT_W-1:0]  words_left;
  logic [5:0]         cur_bits, bits_left;
  logic [WORD_W-1:0]  txsh, rxsh;
  logic [CS_W-1:0]    cs_q;

  // burst geometry from the length field
  logic [TOT_W-1:0]  len_n, len_r, len_up;
  logic [5:0]        first_bits;
  logic [WCNT_W-1:0] n_words;
  always_comb begin
    len_n      = {1'b0, len_m1} + TOT_W'(1);
    len_r      = (len_n + TOT_W'(7)) & ~TOT_W'(7);
    len_up     = len_r + TOT_W'(31);
    n_words    = len_up[TOT_W-1:5];
    first_bits = (len_r[4:0] == 5'd0) ? 6'd32 : {1'b0, len_r[4:0]};
  end

  logic word_go, last_bit;
  assign word_go  = (state == ST_LOAD) && !tx_empty && !rx_full;
  assign last_bit = (state == ST_SHIFT) && sclk && (bits_left == 6'd1);

  assign tx_pop  = en && word_go;
  assign rx_push = en && last_bit;
  assign rx_word = rxsh;
  assign busy    = (state != ST_IDLE);
  assign mosi    = (state == ST_SHIFT) ? txsh[WORD_W-1] : 1'b0;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !(busy && (cs_q == CS_W'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      words_left <= '0;
      cur_bits   <= '0;
      bits_left  <= '0;
      txsh       <= '0;
      rxsh       <= '0;
      cs_q       <= '0;
      sclk       <= 1'b0;
    end else if (!en) begin
      state <= ST_IDLE;
      sclk  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start && !tx_empty) begin
          state      <= ST_LOAD;
          words_left <= n_words;
          cur_bits   <= first_bits;
          cs_q       <= cs_sel;
        end
        ST_LOAD: if (word_go) begin
          txsh      <= tx_word << (6'd32 - cur_bits);
          rxsh      <= '0;
          bits_left <= cur_bits;
          state     <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (!sclk) begin
            sclk <= 1'b1;
            rxsh <= {rxsh[WORD_W-2:0], miso};
          end else begin
            sclk      <= 1'b0;
            txsh      <= txsh << 1;
            bits_left <= bits_left - 6'd1;
            if (bits_left == 6'd1) begin
              if (words_left == WCNT_W'(1)) begin
                state <= ST_IDLE;
              end else begin
                words_left <= words_left - WCNT_W'(1);
                cur_bits   <= 6'd32;
                state      <= ST_LOAD;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int NUM_CS     = 4,
  parameter int LEN_W      = 12,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [1:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int CTRL_W = 2 + CS_W + LEN_W;

  logic              ctrl_en, start, eng_busy;
  logic [CS_W-1:0]   cs_sel;
  logic [LEN_W-1:0]  len_m1;
  logic              tx_push, tx_pop, tx_empty, tx_full;
  logic              rx_push, rx_pop, rx_empty, rx_full;
  logic [WORD_W-1:0] tx_word, rx_word, rx_head;

  spim_regs #(.CS_W(CS_W), .LEN_W(LEN_W), .CTRL_W(CTRL_W)) u_regs (
    .clk, .rst_n,
    .wr_en(bus_wr_en), .rd_en(bus_rd_en), .addr(bus_addr),
    .ctrl_wdata(bus_wdata[CTRL_W-1:0]),
    .tx_empty, .tx_full, .rx_empty, .rx_full, .rx_head,
    .busy(eng_busy), .rdata(bus_rdata),
    .en(ctrl_en), .cs_sel, .len_m1, .start, .tx_push, .rx_pop
  );

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst_n, .clr(!ctrl_en),
    .push(tx_push), .wdata(bus_wdata), .pop(tx_pop),
    .rdata(tx_word), .empty(tx_empty), .full(tx_full)
  );

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst_n, .clr(!ctrl_en),
    .push(rx_push), .wdata(rx_word), .pop(rx_pop),
    .rdata(rx_head), .empty(rx_empty), .full(rx_full)
  );

  spim_engine #(.NUM_CS(NUM_CS), .CS_W(CS_W), .LEN_W(LEN_W)) u_eng (
    .clk, .rst_n, .en(ctrl_en), .start, .cs_sel, .len_m1,
    .tx_empty, .tx_word, .rx_full, .miso(spi_miso),
    .tx_pop, .rx_push, .rx_word, .busy(eng_busy),
    .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n)
  );
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              sclk,
  input logic [NUM_CS-1:0] cs_n,
  input logic              tx_empty
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));                                          // R8
  AST_SCLK_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (cs_n != '1));                                    // R8
  AST_SCLK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> !sclk);                                           // R4
  AST_DIS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((cs_n == '1) && !sclk));                          // R9
  AST_DIS_TX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> tx_empty);                                         // R10
endmodule

bind spim_top spim_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_en), .sclk(spi_sclk),
  .cs_n(spi_cs_n), .tx_empty(tx_empty)
);

// File: tb/spim_top_tb.sv
module spim_top_tb;
  localparam int NCS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sclk, mosi;
  logic [NCS-1:0] cs_n;

  int errors = 0, checks = 0;
  int nbits = 0;
  logic mbits [512];
  logic cs_err = 1'b0;
  logic [NCS-1:0] exp_cs_n = '1;
  logic [31:0] txw [16];

  always #2 clk = ~clk;

  spim_top u_dut (
    .clk, .rst_n, .bus_wr_en(wr), .bus_rd_en(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .spi_sclk(sclk),
    .spi_mosi(mosi), .spi_miso(mosi), .spi_cs_n(cs_n)
  );

  // serial monitor: one bit per clock with sclk high
  always @(negedge clk) if (sclk) begin
    if (nbits < 512) mbits[nbits] = mosi;
    nbits = nbits + 1;
    if (cs_n !== exp_cs_n) cs_err = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 20000; i++) begin
      rd_reg(2'd3, s);
      if (!s[4]) break;
    end
  endtask

  function automatic logic [31:0] pat(input int a, input int b);
    return (32'h9E37_79B9 * (a * 16 + b + 1)) ^ 32'hA5C3_0F11;
  endfunction

  function automatic logic [31:0] ctrl(input bit en, input bit go, input int cs, input int lf);
    return {16'h0, 12'(lf), 2'(cs), go, en};
  endfunction

  task automatic arm(input int cs);
    nbits = 0; cs_err = 1'b0;
    exp_cs_n = ~(NCS'(1) << cs);
  endtask

  // check the bit stream and RX words of a finished burst of nw words
  task automatic check_burst(input int lr, input int nw, input string rq);
    int fb, pos; bit ok; logic [31:0] r, m;
    fb = (lr % 32 == 0) ? 32 : lr % 32;
    chk(nbits == lr, "R2 bit count", nbits, lr);
    ok = 1; pos = 0;
    for (int k = 0; k < nw; k++) begin
      int nb = (k == 0) ? fb : 32;
      for (int i = nb - 1; i >= 0; i--) begin
        if (pos < 512 && mbits[pos] !== txw[k][i]) ok = 0;
        pos++;
      end
    end
    chk(ok, "R3/R4 bit order and word split", 32'(lr), 32'(fb));
    for (int k = 0; k < nw; k++) begin
      int nb = (k == 0) ? fb : 32;
      m = (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 1);
      rd_reg(2'd2, r);
      chk(r === (txw[k] & m), {rq, " R5 rx word"}, r, txw[k] & m);
    end
    chk(!cs_err, "R8 chip select during burst", {31'd0, cs_err}, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    int lr, nw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd_reg(2'd0, v); chk(v === 32'h0, "R1 ctrl reset", v, 32'h0);
    rd_reg(2'd3, v); chk(v === 32'h5, "R11 status reset", v, 32'h5);
    chk(cs_n === '1 && sclk === 1'b0, "R8 idle pins", {27'd0, sclk, cs_n}, 32'hF);

    // control readback
    wr_reg(2'd0, 32'hFFFF_ABC5);
    rd_reg(2'd0, v); chk(v === 32'h0000_ABC5, "R1 ctrl readback", v, 32'h0000_ABC5);

    // start with empty TX is ignored
    wr_reg(2'd0, ctrl(1, 1, 0, 31));
    repeat (5) @(negedge clk);
    rd_reg(2'd3, v); chk(v === 32'h5 && nbits == 0, "R6 start with empty tx", v, 32'h5);

    // write without start does not launch
    wr_reg(2'd1, 32'h1234_5678);
    wr_reg(2'd0, ctrl(1, 0, 0, 31));
    repeat (5) @(negedge clk);
    rd_reg(2'd3, v); chk(v === 32'h4 && nbits == 0, "R6 no start bit", v, 32'h4);
    wr_reg(2'd0, 32'h0); wr_reg(2'd0, ctrl(1, 0, 0, 0));

    // sweep of length fields 0..79
    for (int lf = 0; lf < 80; lf++) begin
      lr = ((lf + 8) / 8) * 8;
      nw = (lr + 31) / 32;
      for (int k = 0; k < nw; k++) begin
        txw[k] = pat(lf, k);
        wr_reg(2'd1, txw[k]);
      end
      arm(lf % NCS);
      wr_reg(2'd0, ctrl(1, 1, lf % NCS, lf));
      wait_idle();
      check_burst(lr, nw, "sweep");
    end

    // TX full: ninth push dropped
    for (int k = 0; k < 9; k++) begin
      txw[k] = pat(90, k);
      wr_reg(2'd1, txw[k]);
    end
    rd_reg(2'd3, v); chk(v === 32'h6, "R11 tx full flag", v, 32'h6);
    arm(1);
    wr_reg(2'd0, ctrl(1, 1, 1, 255));
    wait_idle();
    rd_reg(2'd3, v); chk(v === 32'h9, "R11 ninth word dropped, rx full", v, 32'h9);
    check_burst(256, 8, "full");
    rd_reg(2'd2, v); chk(v === 32'h0, "R11 empty rx read", v, 32'h0);

    // stall on empty TX
    for (int k = 0; k < 3; k++) txw[k] = pat(91, k);
    wr_reg(2'd1, txw[0]);
    arm(2);
    wr_reg(2'd0, ctrl(1, 1, 2, 95));
    repeat (150) @(negedge clk);
    chk(nbits == 32 && sclk === 1'b0 && cs_n === 4'b1011, "R7 stall on empty tx",
        32'(nbits), 32);
    wr_reg(2'd1, txw[1]); wr_reg(2'd1, txw[2]);
    wait_idle();
    check_burst(96, 3, "txstall");

    // stall on full RX
    for (int k = 0; k < 9; k++) txw[k] = pat(92, k);
    for (int k = 0; k < 8; k++) wr_reg(2'd1, txw[k]);
    arm(3);
    wr_reg(2'd0, ctrl(1, 1, 3, 287));
    repeat (700) @(negedge clk);
    wr_reg(2'd1, txw[8]);
    repeat (100) @(negedge clk);
    chk(nbits == 256 && sclk === 1'b0 && cs_n === 4'b0111, "R7 stall on full rx",
        32'(nbits), 256);
    rd_reg(2'd2, v); chk(v === txw[0], "R5 rx word during stall", v, txw[0]);
    wait_idle();
    chk(nbits == 288, "R7 resume after rx read", 32'(nbits), 288);
    for (int k = 1; k < 9; k++) begin
      rd_reg(2'd2, v); chk(v === txw[k], "R5 rx word after stall", v, txw[k]);
    end

    // disable mid-burst
    for (int k = 0; k < 3; k++) wr_reg(2'd1, pat(93, k));
    arm(0);
    wr_reg(2'd0, ctrl(1, 1, 0, 95));
    repeat (40) @(negedge clk);
    wr_reg(2'd0, 32'h0000_0058);
    @(negedge clk);
    chk(cs_n === '1 && sclk === 1'b0, "R9 disable releases pins", {27'd0, sclk, cs_n}, 32'hF);
    rd_reg(2'd0, v); chk(v === 32'h58, "R9 ctrl kept", v, 32'h58);
    rd_reg(2'd3, v); chk(v === 32'h5, "R10 status while disabled", v, 32'h5);
    rd_reg(2'd2, v); chk(v === 32'h0, "R10 rx read while disabled", v, 32'h0);
    wr_reg(2'd1, 32'hDEAD_BEEF);
    wr_reg(2'd0, ctrl(1, 0, 0, 7));
    rd_reg(2'd3, v); chk(v === 32'h5, "R9/R10 fifos flushed, tx write ignored", v, 32'h5);
    nbits = 0;
    wr_reg(2'd0, ctrl(1, 1, 0, 7));
    repeat (40) @(negedge clk);
    chk(nbits == 0, "R10 no data left to send", 32'(nbits), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule